// File: doc/BRIEF.md
# Fixed-Frame SPI Slave Responder

This block is an SPI slave that answers one fixed transaction shape from a master whose timing cannot be adjusted. While select is held low, the master first clocks in a 16-bit header, which should be all zeros. The clock then keeps running with no pause at byte boundaries for 32 more cycles, during which the slave returns one 32-bit word. The master ignores whatever the slave drives while the header is being sent.

The serial pins are oversampled by a system clock of at least 16 times the serial clock rate. Each pin passes through a two-stage synchronizer, and the block detects edges on the synchronized copies. Local logic preloads the response word into a holding register through a valid/ready handshake. When the last header bit arrives, the whole word is copied into the shift register in one step, so no per-byte refill is ever needed.

When select is released, the block reports how the frame went. It raises a one-cycle completion pulse, or a one-cycle error pulse, or both.

Top module: `spi_frame_responder`

## Requirements
- R1: Releasing select clears the bit position. A frame that was cut short has no effect on where the next frame starts, apart from the word already copied for it.
- R2: MISO is driven low while select is released and during all 16 header clocks.
- R3: The response goes out MSB first. The MSB is valid before the 17th rising SCK edge, and each later bit changes only after a falling SCK edge, so it is stable at the next rising edge.
- R4: A word accepted on the parallel port (rsp_valid and rsp_ready both high on a clock edge) is sent in the next frame whose header completes after the acceptance.
- R5: If no word was accepted since the previous header completed, the previous word is sent again.
- R6: A word accepted while a response is being shifted out does not change the bits of that response.
- R7: frame_done pulses for exactly one system clock after select is released, once at least 48 rising SCK edges were seen in the frame.
- R8: frame_err pulses for exactly one system clock after select is released when fewer than 48 rising edges were seen, or when any of the 16 header bits (sampled on the rising edges, first bit is header bit 15) was 1.
- R9: While reset is asserted, the outputs are miso=0, frame_done=0, frame_err=0, and the holding register is cleared, so an unloaded frame after reset returns 0x00000000. rsp_ready is 1 when idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16x the SCK rate |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sck | input | 1 | Serial clock from the master, idles low |
| spi_mosi | input | 1 | Serial data from the master |
| spi_cs_n | input | 1 | Active-low slave select |
| spi_miso | output | 1 | Serial data to the master |
| rsp_data | input | 32 | Response word to preload |
| rsp_valid | input | 1 | rsp_data is offered |
| rsp_ready | output | 1 | Holding register accepts a word this cycle |
| frame_done | output | 1 | One-cycle pulse: frame had all 48 clocks |
| frame_err | output | 1 | One-cycle pulse: short frame or non-zero header |

## Verification
A wrong bit position inside the block shows up at the master's side of the link as a word that is shifted, truncated or padded, from the 17th rising edge onward. The bench compares the whole captured word against the value it loaded. A bad copy from the holding register shows up one frame late, as a stale word or a word that should have been kept. The frames that follow a short frame or a mid-response load catch this. Faults in the end-of-frame status appear within a few system cycles of select going high, and the bench tracks them by counting pulses.

// File: rtl/spi_resp_pkg.sv
// Shared definitions for the fixed-frame SPI responder.
// Assumes: a single serial clock domain that is oversampled by clk.
package spi_resp_pkg;

    // Edge events seen on the synchronized serial pins, valid for one clk cycle.
    typedef struct packed {
        logic sck_rise;   // rising SCK edge
        logic sck_fall;   // falling SCK edge
        logic sel_off;    // select just released (cs_n went high)
    } spi_evt_t;

endpackage

// File: rtl/spi_pin_sync.sv
// Brings the three SPI input pins into the clk domain and flags their edges.
// Assumes: clk is at least 16x the SCK rate, so each SCK level lasts many cycles.
module spi_pin_sync
    import spi_resp_pkg::*;
#(
    parameter int unsigned STAGES = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     sck_pin,
    input  logic     mosi_pin,
    input  logic     csn_pin,
    output spi_evt_t evt,
    output logic     mosi_s,
    output logic     sel_s
);

    localparam logic [2:0] PIN_IDLE = 3'b100;   // {cs_n, mosi, sck} reset levels
    localparam int unsigned LAST = STAGES - 1;

    logic [STAGES-1:0][2:0] chain;
    logic                   sck_q;
    logic                   csn_q;
    logic                   sck_s;
    logic                   csn_s;

    // Shift raw pin levels through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= PIN_IDLE;
        end else begin
            chain[0] <= {csn_pin, mosi_pin, sck_pin};
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    assign sck_s  = chain[LAST][0];
    assign mosi_s = chain[LAST][1];
    assign csn_s  = chain[LAST][2];

    // Keep last synchronized clock and select levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_q <= 1'b0;
            csn_q <= 1'b1;
        end else begin
            sck_q <= sck_s;
            csn_q <= csn_s;
        end
    end

    assign sel_s        = ~csn_s;
    assign evt.sck_rise = sck_s & ~sck_q;
    assign evt.sck_fall = ~sck_s & sck_q;
    assign evt.sel_off  = csn_s & ~csn_q;

endmodule

// File: rtl/spi_frame_ctrl.sv
// Tracks the bit position inside a frame, captures the header and reports frame status.
// Assumes: a frame is HDR_BITS header clocks followed by RSP_BITS response clocks.
module spi_frame_ctrl
    import spi_resp_pkg::*;
#(
    parameter int unsigned HDR_BITS = 16,
    parameter int unsigned RSP_BITS = 32
) (
    input  logic                                       clk,
    input  logic                                       rst_n,
    input  spi_evt_t                                   evt,
    input  logic                                       sel_s,
    input  logic                                       mosi_s,
    output logic                                       load_stb,
    output logic                                       shift_stb,
    output logic                                       resp_phase,
    output logic [$clog2(HDR_BITS+RSP_BITS+1)-1:0]     bit_cnt,
    output logic                                       frame_done,
    output logic                                       frame_err
);

    localparam int unsigned TOTAL = HDR_BITS + RSP_BITS;
    localparam int unsigned CW    = $clog2(TOTAL + 1);
    localparam logic [CW-1:0] HDR_C   = CW'(HDR_BITS);
    localparam logic [CW-1:0] HLAST_C = CW'(HDR_BITS - 1);
    localparam logic [CW-1:0] TOTAL_C = CW'(TOTAL);

    logic [HDR_BITS-1:0] hdr_q;

    // Count rising SCK edges while selected; clear on release; hold at the frame length.
    always_ff @(posedge clk) begin
        if (!rst_n)                                 bit_cnt <= '0;
        else if (!sel_s)                            bit_cnt <= '0;
        else if (evt.sck_rise && bit_cnt < TOTAL_C) bit_cnt <= bit_cnt + 1'b1;
    end

    // Collect header bits from MOSI on rising edges, first bit ends up on top.
    always_ff @(posedge clk) begin
        if (!rst_n || !sel_s)
            hdr_q <= '0;
        else if (evt.sck_rise && bit_cnt < HDR_C)
            hdr_q <= {hdr_q[HDR_BITS-2:0], mosi_s};
    end

    // Judge the finished frame at the moment select is released.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_done <= 1'b0;
            frame_err  <= 1'b0;
        end else if (evt.sel_off) begin
            frame_done <= (bit_cnt == TOTAL_C);
            frame_err  <= (bit_cnt != TOTAL_C) || (|hdr_q);
        end else begin
            frame_done <= 1'b0;
            frame_err  <= 1'b0;
        end
    end

    // Copy the response in on the last header edge; shift after each later falling edge.
    assign load_stb   = sel_s && evt.sck_rise && (bit_cnt == HLAST_C);
    assign shift_stb  = sel_s && evt.sck_fall && (bit_cnt > HDR_C) && (bit_cnt < TOTAL_C);
    assign resp_phase = sel_s && (bit_cnt >= HDR_C);

endmodule

// File: rtl/spi_tx_path.sv
// Holds the preloaded response word and shifts it out MSB first.
// Assumes: load_stb and shift_stb never occur in the same cycle.
module spi_tx_path #(
    parameter int unsigned RSP_BITS = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [RSP_BITS-1:0] rsp_data,
    input  logic                rsp_valid,
    output logic                rsp_ready,
    input  logic                load_stb,
    input  logic                shift_stb,
    input  logic                resp_phase,
    output logic                miso
);

    localparam int unsigned MSB = RSP_BITS - 1;

    logic [RSP_BITS-1:0] hold_q;
    logic [RSP_BITS-1:0] shreg_q;

    // Refuse a new word only in the cycle the hold register is being copied.
    assign rsp_ready = ~load_stb;

    // Accept a new response word on a handshake.
    always_ff @(posedge clk) begin
        if (!rst_n)                      hold_q <= '0;
        else if (rsp_valid && rsp_ready) hold_q <= rsp_data;
    end

    // Copy the whole word at header end, then move it one bit per falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n)         shreg_q <= '0;
        else if (load_stb)  shreg_q <= hold_q;
        else if (shift_stb) shreg_q <= {shreg_q[MSB-1:0], 1'b0};
    end

    // Register the pin: top bit during the response, low otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) miso <= 1'b0;
        else        miso <= resp_phase ? shreg_q[MSB] : 1'b0;
    end

endmodule

// File: rtl/spi_frame_responder.sv
// SPI slave for a fixed frame: header in, then a preloaded word out, SCK idle low,
// master samples on the rising edge. Assumes clk >= 16x SCK.
module spi_frame_responder
    import spi_resp_pkg::*;
#(
    parameter int unsigned HDR_BITS    = 16,
    parameter int unsigned RSP_BITS    = 32,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                spi_sck,
    input  logic                spi_mosi,
    input  logic                spi_cs_n,
    output logic                spi_miso,
    input  logic [RSP_BITS-1:0] rsp_data,
    input  logic                rsp_valid,
    output logic                rsp_ready,
    output logic                frame_done,
    output logic                frame_err
);

    localparam int unsigned CW = $clog2(HDR_BITS + RSP_BITS + 1);

    spi_evt_t        evt;
    logic            mosi_s;
    logic            sel_s;
    logic            load_stb;
    logic            shift_stb;
    logic            resp_phase;
    logic [CW-1:0]   bit_cnt;

    spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck_pin  (spi_sck),
        .mosi_pin (spi_mosi),
        .csn_pin  (spi_cs_n),
        .evt      (evt),
        .mosi_s   (mosi_s),
        .sel_s    (sel_s)
    );

    spi_frame_ctrl #(.HDR_BITS(HDR_BITS), .RSP_BITS(RSP_BITS)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt        (evt),
        .sel_s      (sel_s),
        .mosi_s     (mosi_s),
        .load_stb   (load_stb),
        .shift_stb  (shift_stb),
        .resp_phase (resp_phase),
        .bit_cnt    (bit_cnt),
        .frame_done (frame_done),
        .frame_err  (frame_err)
    );

    spi_tx_path #(.RSP_BITS(RSP_BITS)) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .rsp_data   (rsp_data),
        .rsp_valid  (rsp_valid),
        .rsp_ready  (rsp_ready),
        .load_stb   (load_stb),
        .shift_stb  (shift_stb),
        .resp_phase (resp_phase),
        .miso       (spi_miso)
    );

endmodule

// File: rtl/spi_frame_responder_chk.sv
// Temporal checks on the responder, attached through bind.
// Assumes: select is not re-asserted within one clk of its release.
module spi_frame_responder_chk #(
    parameter int unsigned HDR_BITS = 16,
    parameter int unsigned RSP_BITS = 32
) (
    input logic                                   clk,
    input logic                                   rst_n,
    input logic                                   sel_s,
    input logic [$clog2(HDR_BITS+RSP_BITS+1)-1:0] bit_cnt,
    input logic                                   spi_miso,
    input logic                                   frame_done,
    input logic                                   frame_err
);

    localparam int unsigned CW = $clog2(HDR_BITS + RSP_BITS + 1);
    localparam logic [CW-1:0] HDR_C = CW'(HDR_BITS);

    AST_CNT_CLEARED: assert property (@(posedge clk) disable iff (!rst_n) !sel_s |=> bit_cnt == '0); // R1
    AST_MISO_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n) !sel_s |=> !spi_miso); // R2
    AST_MISO_HDR_LOW: assert property (@(posedge clk) disable iff (!rst_n) (sel_s && bit_cnt < HDR_C) |=> !spi_miso); // R2
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) frame_done |=> !frame_done); // R7
    AST_DONE_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n) frame_done |-> !sel_s); // R7
    AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n) frame_err |=> !frame_err); // R8

endmodule

bind spi_frame_responder spi_frame_responder_chk #(.HDR_BITS(HDR_BITS), .RSP_BITS(RSP_BITS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel_s      (sel_s),
    .bit_cnt    (bit_cnt),
    .spi_miso   (spi_miso),
    .frame_done (frame_done),
    .frame_err  (frame_err)
);

// File: tb/spi_frame_responder_test.sv
`timescale 1ns/1ps
module spi_frame_responder_test;

    localparam int HALF = 20;   // system cycles per SCK half period

    typedef struct packed {
        logic        ld;
        logic [31:0] word;
        logic [15:0] hdr;
        logic [5:0]  nclk;
        logic        mid;
        logic [31:0] mid_word;
        logic [31:0] exp;
        logic        chk;
        logic        exp_done;
        logic        exp_err;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 32'hA5A50F0F, 16'h0000, 6'd48, 1'b0, 32'h0, 32'hA5A50F0F, 1'b1, 1'b1, 1'b0},
        '{1'b1, 32'h80000001, 16'h0000, 6'd48, 1'b0, 32'h0, 32'h80000001, 1'b1, 1'b1, 1'b0},
        '{1'b0, 32'h00000000, 16'h0000, 6'd48, 1'b0, 32'h0, 32'h80000001, 1'b1, 1'b1, 1'b0},
        '{1'b1, 32'hFFFFFFFF, 16'h0100, 6'd48, 1'b0, 32'h0, 32'hFFFFFFFF, 1'b1, 1'b1, 1'b1},
        '{1'b1, 32'h12345678, 16'h0000, 6'd30, 1'b0, 32'h0, 32'h00000000, 1'b0, 1'b0, 1'b1},
        '{1'b0, 32'h00000000, 16'h0000, 6'd48, 1'b0, 32'h0, 32'h12345678, 1'b1, 1'b1, 1'b0},
        '{1'b0, 32'h00000000, 16'h0000, 6'd8,  1'b0, 32'h0, 32'h00000000, 1'b0, 1'b0, 1'b1},
        '{1'b0, 32'h00000000, 16'h0000, 6'd48, 1'b1, 32'hDEADBEEF, 32'h12345678, 1'b1, 1'b1, 1'b0},
        '{1'b0, 32'h00000000, 16'h0000, 6'd48, 1'b0, 32'h0, 32'hDEADBEEF, 1'b1, 1'b1, 1'b0},
        '{1'b1, 32'h0000FFFF, 16'h8000, 6'd48, 1'b0, 32'h0, 32'h0000FFFF, 1'b1, 1'b1, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        spi_sck = 1'b0;
    logic        spi_mosi = 1'b0;
    logic        spi_cs_n = 1'b1;
    logic        spi_miso;
    logic [31:0] rsp_data = '0;
    logic        rsp_valid = 1'b0;
    logic        rsp_ready;
    logic        frame_done;
    logic        frame_err;

    int n_tests = 0;
    int n_fail  = 0;
    int done_cnt = 0;
    int err_cnt  = 0;

    always #2 clk = ~clk;

    spi_frame_responder uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .spi_sck    (spi_sck),
        .spi_mosi   (spi_mosi),
        .spi_cs_n   (spi_cs_n),
        .spi_miso   (spi_miso),
        .rsp_data   (rsp_data),
        .rsp_valid  (rsp_valid),
        .rsp_ready  (rsp_ready),
        .frame_done (frame_done),
        .frame_err  (frame_err)
    );

    // Count status pulses seen on the ports.
    always @(posedge clk) begin
        if (rst_n && frame_done) done_cnt++;
        if (rst_n && frame_err)  err_cnt++;
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic half_wait();
        repeat (HALF) @(negedge clk);
    endtask

    task automatic load_word(input logic [31:0] w);
        @(negedge clk);
        rsp_valid = 1'b1;
        rsp_data  = w;
        while (!rsp_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        rsp_valid = 1'b0;
    endtask

    task automatic run_frame(input logic [15:0] hdr, input int nclk, input bit mid_ld,
                             input logic [31:0] mid_word, output logic [31:0] cap,
                             output bit hdr_hi);
        cap = '0;
        hdr_hi = 1'b0;
        @(negedge clk);
        spi_cs_n = 1'b0;
        half_wait();
        for (int i = 0; i < nclk; i++) begin
            spi_mosi = (i < 16) ? hdr[15-i] : 1'b0;
            if (mid_ld && i == 30) load_word(mid_word);
            half_wait();
            if (i >= 16) cap = {cap[30:0], spi_miso};
            else if (spi_miso) hdr_hi = 1'b1;
            spi_sck = 1'b1;
            half_wait();
            spi_sck = 1'b0;
        end
        half_wait();
        spi_cs_n = 1'b1;
        spi_mosi = 1'b0;
        repeat (10) @(negedge clk);
    endtask

    initial begin
        #2000000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] cap;
        bit          hdr_hi;
        int          d0;
        int          e0;

        repeat (5) @(negedge clk);
        // R9: outputs during reset
        check(spi_miso == 1'b0 && frame_done == 1'b0 && frame_err == 1'b0, "R9 reset outputs",
              {29'd0, spi_miso, frame_done, frame_err}, 32'd0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check(rsp_ready == 1'b1, "R9 idle ready", {31'd0, rsp_ready}, 32'd1);

        for (int v = 0; v < NV; v++) begin
            if (VECS[v].ld) load_word(VECS[v].word);
            d0 = done_cnt;
            e0 = err_cnt;
            run_frame(VECS[v].hdr, int'(VECS[v].nclk), VECS[v].mid, VECS[v].mid_word, cap, hdr_hi);
            // R3 R4 R5 R6: captured response word
            if (VECS[v].chk)
                check(cap == VECS[v].exp, $sformatf("R3/R4 R5 R6 vec %0d word", v), cap, VECS[v].exp);
            // R2: MISO low through the header and after release
            check(!hdr_hi, $sformatf("R2 vec %0d header miso", v), {31'd0, hdr_hi}, 32'd0);
            check(spi_miso == 1'b0, $sformatf("R2 vec %0d idle miso", v), {31'd0, spi_miso}, 32'd0);
            // R7: completion pulse count
            check(done_cnt - d0 == int'(VECS[v].exp_done), $sformatf("R7 vec %0d done", v),
                  32'(done_cnt - d0), {31'd0, VECS[v].exp_done});
            // R8 R1: error pulse count
            check(err_cnt - e0 == int'(VECS[v].exp_err), $sformatf("R8 R1 vec %0d err", v),
                  32'(err_cnt - e0), {31'd0, VECS[v].exp_err});
        end

        // R9: reset clears the holding register
        load_word(32'hAAAA5555);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        check(spi_miso == 1'b0 && frame_done == 1'b0 && frame_err == 1'b0, "R9 reset again",
              {29'd0, spi_miso, frame_done, frame_err}, 32'd0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        run_frame(16'h0000, 48, 1'b0, 32'h0, cap, hdr_hi);
        check(cap == 32'h00000000, "R9 word after reset", cap, 32'h00000000);

        // R1: short frame cut inside the header, then a full frame loads its own word
        load_word(32'h0F1E2D3C);
        run_frame(16'h0000, 5, 1'b0, 32'h0, cap, hdr_hi);
        run_frame(16'h0000, 48, 1'b0, 32'h0, cap, hdr_hi);
        check(cap == 32'h0F1E2D3C, "R1 realign after short frame", cap, 32'h0F1E2D3C);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule